// File: doc/BRIEF.md
# Nesting Priority Interrupt Controller

This block collects interrupt requests from eleven maskable sources and one nonmaskable input. It picks the most urgent request that may run now and presents it to the processor on a single request line, along with a vector type code. The maskable sources are three timers, two DMA channels, one serial port and five external pins. The processor takes one interrupt at a time by pulsing an acknowledge. That marks the source as in service and closes the interrupt-enable flag until the processor opens it again.

Each maskable source has a mask bit and a programmable 3-bit priority. While a service routine runs, only requests of equal or higher urgency may break in. A source cannot re-enter its own routine until an end-of-interrupt command retires it. The two lowest external inputs each have a fully nested option that lifts this limit for that input. A slave mode bit leaves arbitration to an external master controller: the block then presents no maskable request of its own, and the nonmaskable input still works. Mask, priority, nesting and mode settings arrive as static configuration inputs from the surrounding register file.

Top module: `picn_top`

## Requirements
- R1: While reset is low, and right after it, `irq_o` is low, `inservice_o` is all zero, and the enable flag is clear. A pending maskable request is not presented until `en_set_i` has pulsed.
- R2: Source indices run as follows: timers 0–2, DMA channels 3–4, serial port 5, external inputs 6–10 (external input 0 is index 6). A request seen on `req_i[k]` at a clock edge stays pending. If it is unmasked, eligible and the enable flag is set, `irq_o` is high after that edge and `vector_o` = 8 + k. An acknowledge clears the pending bit and sets `inservice_o[k]`.
- R3: Among eligible requests, the lowest 3-bit priority value (`prio_i[3k+2:3k]`) wins. On equal values, the lower index wins.
- R4: An acknowledge taken while `irq_o` is high clears the enable flag. No maskable request is presented again until `en_set_i` pulses.
- R5: While any source is in service, a maskable request is presented only if its priority value is less than or equal to the lowest priority value among the in-service sources.
- R6: A source whose in-service bit is set is not presented, while another source with the same priority value still is.
- R7: With `sfnm_i[0]` (index 6) or `sfnm_i[1]` (index 7) set, that input is presented again even though its in-service bit is set.
- R8: A rising edge on `nmi_i` makes `irq_o` high after the next edge with `vector_o` = 2. This happens regardless of masks, the enable flag and slave mode, and it beats any maskable request. Holding `nmi_i` high raises no second request.
- R9: A pulse on `eoi_i` clears the in-service bit of the highest-priority in-service source (lowest value, ties to the lower index).
- R10: With `slave_i` high, no maskable request is presented.
- R11: A set `mask_i[k]` keeps source k from being presented. Its request stays pending and appears once the mask is cleared.
- R12: An acknowledge while `irq_o` is low changes neither the enable flag nor `inservice_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 11 | Maskable request lines, by source index |
| nmi_i | input | 1 | Nonmaskable request, edge-sensitive |
| mask_i | input | 11 | Mask bit per source, 1 blocks |
| prio_i | input | 33 | 3-bit priority per source, 0 most urgent |
| sfnm_i | input | 2 | Fully nested option for external inputs 0 and 1 |
| slave_i | input | 1 | Slave mode: own maskable arbitration off |
| en_set_i | input | 1 | Pulse that sets the interrupt-enable flag |
| ack_i | input | 1 | Processor acknowledge |
| eoi_i | input | 1 | End-of-interrupt command |
| irq_o | output | 1 | Interrupt request to the processor |
| vector_o | output | 8 | Vector type of the presented request |
| inservice_o | output | 11 | In-service register |

## Verification
The bench builds the block with its default parameters: three timers, two DMA channels, one serial port, five external inputs, two fully nested inputs, 3-bit priorities, vector base 8 and nonmaskable vector 2. With these values the bench can set ties between sources at one level and preemption by an equal level while another source is in service. It can also test blocking at a strictly lower level and the fully nested escape on index 6. Because every source index and priority is a fixed small number, each expected vector follows directly from the requirement.

// File: rtl/picn_pkg.sv
`timescale 1ns/1ps
package picn_pkg;
   localparam int VEC_W = 8;

   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/picn_minsel.sv
`timescale 1ns/1ps
// Finds the most urgent valid entry: lowest priority value, ties to the lowest index.
module picn_minsel #(
   parameter int N  = 11,
   parameter int PW = 3,
   localparam int IW = picn_pkg::idx_w(N)
) (
   input  logic [N-1:0]    valid_i,
   input  logic [N*PW-1:0] prio_i,
   output logic            found_o,
   output logic [IW-1:0]   idx_o,
   output logic [PW-1:0]   best_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      best_o  = '1;
      for (int i = 0; i < N; i++) begin
         if (valid_i[i] && (!found_o || (prio_i[i*PW +: PW] < best_o))) begin
            found_o = 1'b1;
            idx_o   = IW'(i);
            best_o  = prio_i[i*PW +: PW];
         end
      end
   end
endmodule

// File: rtl/picn_nmi_latch.sv
`timescale 1ns/1ps
// Edge capture for the nonmaskable input; a new edge wins over a clear.
module picn_nmi_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_i,
   input  logic clr_i,
   output logic pend_o
);
   logic prev_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         pend_o <= 1'b0;
      end else begin
         prev_q <= nmi_i;
         if (nmi_i && !prev_q) pend_o <= 1'b1;
         else if (clr_i)       pend_o <= 1'b0;
      end
   end
endmodule

// File: rtl/picn_top.sv
`timescale 1ns/1ps
module picn_top #(
   parameter int N_TMR    = 3,
   parameter int N_DMA    = 2,
   parameter int N_SER    = 1,
   parameter int N_EXT    = 5,
   parameter int N_SFNM   = 2,
   parameter int PRIO_W   = 3,
   parameter int VEC_BASE = 8,
   parameter int NMI_VEC  = 2,
   localparam int NSRC    = N_TMR + N_DMA + N_SER + N_EXT,
   localparam int EXT_LO  = N_TMR + N_DMA + N_SER,
   localparam int IW      = picn_pkg::idx_w(NSRC),
   localparam int VW      = picn_pkg::VEC_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NSRC-1:0]        req_i,
   input  logic                   nmi_i,
   input  logic [NSRC-1:0]        mask_i,
   input  logic [NSRC*PRIO_W-1:0] prio_i,
   input  logic [N_SFNM-1:0]      sfnm_i,
   input  logic                   slave_i,
   input  logic                   en_set_i,
   input  logic                   ack_i,
   input  logic                   eoi_i,
   output logic                   irq_o,
   output logic [VW-1:0]          vector_o,
   output logic [NSRC-1:0]        inservice_o
);
   // elaboration-time parameter checks
   if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_prio
      $error("PRIO_W must be 1..8");
   end
   if (N_SFNM < 1 || N_SFNM > N_EXT) begin : g_bad_sfnm
      $error("N_SFNM must be 1..N_EXT");
   end
   if (VEC_BASE + NSRC > (1 << VW) || NMI_VEC >= (1 << VW)) begin : g_bad_vec
      $error("vector codes exceed vector width");
   end

   logic [NSRC-1:0] pend_q, isr_q, elig, nest_ok;
   logic            en_q, nmi_pend;
   logic            m_found, cur_any;
   logic [IW-1:0]   win_idx, cur_idx;
   logic [PRIO_W-1:0] win_prio, cur_prio;
   logic            take, take_nmi, take_m;

   // per-source fully nested option: only the lowest external inputs carry it
   for (genvar g = 0; g < NSRC; g++) begin : g_nest
      if (g >= EXT_LO && g < EXT_LO + N_SFNM) begin : g_on
         assign nest_ok[g] = sfnm_i[g - EXT_LO];
      end else begin : g_off
         assign nest_ok[g] = 1'b0;
      end
   end

   // current service level: most urgent in-service source
   picn_minsel #(.N(NSRC), .PW(PRIO_W)) u_level (
      .valid_i(isr_q), .prio_i(prio_i),
      .found_o(cur_any), .idx_o(cur_idx), .best_o(cur_prio)
   );

   always_comb begin
      for (int i = 0; i < NSRC; i++) begin
         elig[i] = pend_q[i] && !mask_i[i]
                && (!isr_q[i] || nest_ok[i])
                && (!cur_any || (prio_i[i*PRIO_W +: PRIO_W] <= cur_prio));
      end
   end

   picn_minsel #(.N(NSRC), .PW(PRIO_W)) u_win (
      .valid_i(elig), .prio_i(prio_i),
      .found_o(m_found), .idx_o(win_idx), .best_o(win_prio)
   );

   picn_nmi_latch u_nmi (
      .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i),
      .clr_i(take_nmi), .pend_o(nmi_pend)
   );

   assign irq_o    = nmi_pend || (en_q && !slave_i && m_found);
   assign vector_o = nmi_pend ? VW'(NMI_VEC) : (VW'(VEC_BASE) + VW'(win_idx));
   assign take     = ack_i && irq_o;
   assign take_nmi = take && nmi_pend;
   assign take_m   = take && !nmi_pend;
   assign inservice_o = isr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         pend_q <= '0;
         isr_q  <= '0;
      end else begin
         if (take)          en_q <= 1'b0;
         else if (en_set_i) en_q <= 1'b1;
         for (int i = 0; i < NSRC; i++) begin
            if (take_m && (IW'(i) == win_idx)) pend_q[i] <= 1'b0;
            else                               pend_q[i] <= pend_q[i] | req_i[i];
            if (take_m && (IW'(i) == win_idx))                  isr_q[i] <= 1'b1;
            else if (eoi_i && cur_any && (IW'(i) == cur_idx))   isr_q[i] <= 1'b0;
         end
      end
   end

   // ---------------- assertions ----------------
   a_r4_take_closes_enable: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> !en_q);

   a_r8_nmi_edge_raises: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nmi_i) |=> (irq_o && vector_o == VW'(NMI_VEC)));

   a_r2_take_marks_service: assert property (@(posedge clk) disable iff (!rst_n)
      (take_m && !eoi_i) |=> isr_q[$past(win_idx)]);

   a_r9_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_i && (isr_q != '0) && !take) |=>
         ($countones(isr_q) == $countones($past(isr_q)) - 1));

   a_r6_no_self_reentry: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !nmi_pend) |-> !(isr_q[win_idx] && !nest_ok[win_idx]));

   a_r5_level_respected: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !nmi_pend && cur_any) |-> (win_prio <= cur_prio));

   a_r12_idle_ack_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !irq_o && !eoi_i) |=> $stable(isr_q));
endmodule

// File: tb/sim_picn_top.sv
`timescale 1ns/1ps
module sim_picn_top;
   localparam int NS = 11;
   localparam int PW = 3;

   logic clk = 1'b0;
   logic rst_n;
   logic [NS-1:0] req, mask;
   logic [NS*PW-1:0] prio;
   logic [1:0] sfnm;
   logic nmi, slave, en_set, ack, eoi;
   logic irq;
   logic [7:0] vec;
   logic [NS-1:0] isr;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   picn_top u0 (
      .clk(clk), .rst_n(rst_n), .req_i(req), .nmi_i(nmi), .mask_i(mask),
      .prio_i(prio), .sfnm_i(sfnm), .slave_i(slave), .en_set_i(en_set),
      .ack_i(ack), .eoi_i(eoi), .irq_o(irq), .vector_o(vec), .inservice_o(isr)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_irq(input string tag, input bit e_irq, input int e_vec);
      chk(irq == e_irq, tag, irq, e_irq);
      if (e_irq) chk(vec == 8'(e_vec), tag, vec, e_vec);
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic set_prio(input int k, input int p);
      prio[k*PW +: PW] = PW'(p);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; req = '0; mask = '0; sfnm = '0; nmi = 1'b0; slave = 1'b0;
      en_set = 1'b0; ack = 1'b0; eoi = 1'b0;
      for (int k = 0; k < NS; k++) set_prio(k, 4);
      tick(); tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic pulse_req(input int k);
      req[k] = 1'b1; tick(); req[k] = 1'b0;
   endtask

   task automatic pulse_en();
      en_set = 1'b1; tick(); en_set = 1'b0;
   endtask

   task automatic pulse_eoi();
      eoi = 1'b1; tick(); eoi = 1'b0;
   endtask

   // acknowledge, checking the vector in the acknowledge cycle
   task automatic do_ack(input string tag, input int e_vec);
      ack = 1'b1; #1;
      chk(vec == 8'(e_vec), tag, vec, e_vec);
      tick(); ack = 1'b0;
   endtask

   task automatic t_reset();
      do_reset();
      chk(irq == 1'b0, "R1 irq low after reset", irq, 0);
      chk(isr == '0, "R1 in-service clear", int'(isr), 0);
      pulse_req(0); tick();
      chk(irq == 1'b0, "R1 enable flag clear", irq, 0);
   endtask

   task automatic t_basic();
      do_reset();
      en_set = 1'b1; req[5] = 1'b1; tick(); en_set = 1'b0; req[5] = 1'b0;
      chk_irq("R2 serial presented", 1, 13);
      do_ack("R2 vector at ack", 13);
      chk(isr == NS'(1 << 5), "R2 in-service set", int'(isr), 1 << 5);
      chk(irq == 1'b0, "R2 pending cleared", irq, 0);
   endtask

   task automatic t_prio();
      do_reset();
      set_prio(2, 3); set_prio(9, 1); set_prio(4, 1);
      req[2] = 1'b1; req[9] = 1'b1; req[4] = 1'b1; en_set = 1'b1; tick();
      req = '0; en_set = 1'b0;
      chk_irq("R3 lowest value, tie to low index", 1, 12);
      do_ack("R3 vector", 12);
      chk(irq == 1'b0, "R4 enable closed by ack", irq, 0);
      tick();
      chk(irq == 1'b0, "R4 stays closed", irq, 0);
      pulse_en();
      chk_irq("R5 equal level preempts", 1, 17);
      do_ack("R5 vector", 17);
      pulse_en();
      chk(irq == 1'b0, "R5 lower level waits", irq, 0);
      pulse_eoi();
      chk(isr == NS'(1 << 9), "R9 eoi retires tie-winner index 4", int'(isr), 1 << 9);
      pulse_eoi();
      chk(isr == '0, "R9 eoi retires index 9", int'(isr), 0);
      chk_irq("R9 lower level released", 1, 10);
   endtask

   task automatic t_block();
      do_reset();
      for (int k = 0; k < NS; k++) set_prio(k, 2);
      en_set = 1'b1; req[6] = 1'b1; tick(); en_set = 1'b0; req[6] = 1'b0;
      do_ack("R6 first entry", 14);
      req[6] = 1'b1; en_set = 1'b1; tick(); req[6] = 1'b0; en_set = 1'b0;
      chk(irq == 1'b0, "R6 self blocked", irq, 0);
      pulse_req(8);
      chk_irq("R6 peer at same level allowed", 1, 16);
      do_reset();
      sfnm = 2'b01;
      en_set = 1'b1; req[6] = 1'b1; tick(); en_set = 1'b0; req[6] = 1'b0;
      do_ack("R7 first entry", 14);
      req[6] = 1'b1; en_set = 1'b1; tick(); req[6] = 1'b0; en_set = 1'b0;
      chk_irq("R7 nested re-entry", 1, 14);
   endtask

   task automatic t_nmi();
      do_reset();
      mask = '1;
      nmi = 1'b1; tick();
      chk_irq("R8 nmi ignores mask and enable", 1, 2);
      do_ack("R8 nmi vector", 2);
      chk(irq == 1'b0, "R8 held level no retrigger", irq, 0);
      chk(isr == '0, "R8 no in-service bit", int'(isr), 0);
      nmi = 1'b0; tick(); nmi = 1'b1; tick();
      chk_irq("R8 new edge", 1, 2);
      do_ack("R8 second ack", 2);
      nmi = 1'b0;
      do_reset();
      set_prio(0, 0);
      en_set = 1'b1; req[0] = 1'b1; nmi = 1'b1; tick(); en_set = 1'b0; req[0] = 1'b0;
      chk_irq("R8 nmi beats maskable", 1, 2);
      nmi = 1'b0;
   endtask

   task automatic t_slave();
      do_reset();
      slave = 1'b1;
      en_set = 1'b1; req[1] = 1'b1; tick(); en_set = 1'b0; req[1] = 1'b0;
      chk(irq == 1'b0, "R10 slave holds off maskable", irq, 0);
      nmi = 1'b1; tick();
      chk_irq("R10 nmi still served", 1, 2);
      nmi = 1'b0;
   endtask

   task automatic t_mask();
      do_reset();
      mask[3] = 1'b1;
      en_set = 1'b1; req[3] = 1'b1; tick(); en_set = 1'b0; req[3] = 1'b0;
      chk(irq == 1'b0, "R11 masked", irq, 0);
      mask[3] = 1'b0; #1;
      chk_irq("R11 pending kept", 1, 11);
   endtask

   task automatic t_idle_ack();
      do_reset();
      pulse_en();
      ack = 1'b1; tick(); ack = 1'b0;
      chk(isr == '0, "R12 idle ack leaves in-service", int'(isr), 0);
      pulse_req(1);
      chk_irq("R12 enable survives idle ack", 1, 9);
   endtask

   task automatic finish_run();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      t_reset();
      t_basic();
      t_prio();
      t_block();
      t_nmi();
      t_slave();
      t_mask();
      t_idle_ack();
      finish_run();
   end
endmodule